// File: doc/BRIEF.md
# Cache Line Range Clean Sequencer

This block walks a physical address range and emits one write-back (clean) request for every data-cache line the range touches. A controller gives it a start address, an exclusive stop address and the line size. The size is given twice: as a byte count and as its base-2 logarithm. The controller pulses `go`. The block rounds the start down to a line boundary and works out the number of lines. It then brackets the per-line loop with a translation-off window and two barriers. It signals `done` once everything has drained.

The line count is `((stop - aligned_start) + (line_bytes - 1)) >> line_lg2`. With this formula, a partly covered last line is still cleaned. When the count is zero, the block finishes at once and emits nothing. The clean requests and the barriers each leave on a valid/ready channel. A request is held, unchanged, until the sink accepts it. The sink may hold `ready` low for any number of cycles.

Top module: `line_clean_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `xlat_off`, `bar_valid` and `cl_valid` are all low.
- R2: The first clean address equals `range_lo` with its low `line_lg2` bits cleared.
- R3: The number of accepted clean requests (cycles with `cl_valid` and `cl_ready` both high) is 0 if `range_hi` is below the aligned start. Otherwise it is `(range_hi - aligned + line_bytes - 1) >> line_lg2`, computed without overflow.
- R4: Each accepted request's address is exactly `line_bytes` above the previous one, so addresses ascend. The range must not wrap past the top of the address space.
- R5: When the count is zero, no request or barrier is issued and `xlat_off` stays low. `done` is high in the cycle after `go` is taken.
- R6: For a nonzero count, `xlat_off` goes high, and an opening barrier is accepted before any clean request. After the last request, a closing barrier is accepted while `xlat_off` is still high. `xlat_off` is low when `done` shows. Exactly two barriers are accepted per operation, and a barrier and a request are never offered together.
- R7: While `cl_valid` is high and `cl_ready` is low, the next cycle still offers `cl_valid` with the same `cl_addr`. `bar_valid` likewise stays high until `bar_ready`.
- R8: `done` is a one-cycle pulse. It follows acceptance of the closing barrier, and `busy` is low in the next cycle.
- R9: `go` is ignored while `busy` is high. The range inputs are sampled only when `go` is taken.
- R10: The configuration is invalid if `line_lg2` is outside 4..8 or if `line_bytes` is not `1 << line_lg2`. When `go` is taken with an invalid configuration, `err` goes high, no request or barrier is issued, and `done` pulses in the next cycle. `err` holds until the next `go` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| range_lo | input | AW | First byte address of the range |
| range_hi | input | AW | Address one past the last byte |
| line_lg2 | input | 4 | log2 of the line size |
| line_bytes | input | 9 | Line size in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last taken `go` had an invalid line configuration |
| xlat_off | output | 1 | Data address translation must be held off |
| bar_valid | output | 1 | Barrier request offered |
| bar_ready | input | 1 | Barrier sink accepts |
| cl_valid | output | 1 | Clean request offered |
| cl_ready | input | 1 | Clean sink accepts |
| cl_addr | output | AW | Line address of the clean request |

## Verification
The assertions assume that the range never crosses the top of the address space, since the ascending-address check compares raw addresses. They make no assumption about `ready`, which may drop or rise in any cycle. The stimulus keeps start addresses below the midpoint of the space and limits range lengths to a few kilobytes. It drives both ready lines from $urandom on the falling edge. It also adds directed cases: a stop below the start, an empty range, a one-byte span, and invalid size pairs.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_WALK,
    ST_CLOSE,
    ST_FIN
  } lcs_state_e;
endpackage

// File: rtl/lcs_range_calc.sv
// Aligns the start, derives the line count and validates the size pair.
module lcs_range_calc #(
  parameter int AW     = 32,
  parameter int LGW    = 4,
  parameter int LBW    = 9,
  parameter int MIN_LG = 4,
  parameter int MAX_LG = 8
) (
  input  logic [AW-1:0]  lo,
  input  logic [AW-1:0]  hi,
  input  logic [LGW-1:0] lg,
  input  logic [LBW-1:0] lb,
  output logic [AW-1:0]  base,
  output logic [AW:0]    lines,
  output logic           cfg_bad
);
  logic [AW-1:0]  mask;
  logic [LBW-1:0] pow;
  logic [AW:0]    span;

  always_comb begin
    for (int i = 0; i < AW; i++) mask[i] = (i < int'(lg));
    for (int j = 0; j < LBW; j++) pow[j] = (int'(lg) == j);
  end

  assign base    = lo & ~mask;
  // extra top bit keeps the rounded-up length from overflowing
  assign span    = {1'b0, hi} - {1'b0, base} + {1'b0, mask};
  assign lines   = (hi < base) ? '0 : (span >> lg);
  assign cfg_bad = (int'(lg) < MIN_LG) || (int'(lg) > MAX_LG) || (lb != pow);
endmodule

// File: rtl/lcs_walker.sv
// Holds the current line address and the number of lines left.
module lcs_walker #(
  parameter int AW  = 32,
  parameter int LBW = 9,
  localparam int CW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  base,
  input  logic [CW-1:0]  lines,
  input  logic [LBW-1:0] step_bytes,
  input  logic           adv,
  output logic [AW-1:0]  addr,
  output logic           last
);
  logic [AW-1:0] addr_q, step_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= base;
      step_q <= {{(AW-LBW){1'b0}}, step_bytes};
      left_q <= lines;
    end else if (adv) begin
      addr_q <= addr_q + step_q;
      left_q <= left_q - 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = (left_q == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/lcs_ctrl.sv
// Sequencing: open barrier, per-line loop, close barrier, completion.
module lcs_ctrl
  import lcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic lines_zero,
  input  logic cfg_bad,
  input  logic last,
  input  logic cl_ready,
  input  logic bar_ready,
  output logic load,
  output logic adv,
  output logic cl_valid,
  output logic bar_valid,
  output logic xlat_off,
  output logic busy,
  output logic done,
  output logic err
);
  lcs_state_e state_q, state_d;
  logic       err_q;
  logic       take;

  assign take = go && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take) state_d = (cfg_bad || lines_zero) ? ST_FIN : ST_OPEN;
      ST_OPEN:  if (bar_ready) state_d = ST_WALK;
      ST_WALK:  if (cl_ready && last) state_d = ST_CLOSE;
      ST_CLOSE: if (bar_ready) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) err_q <= cfg_bad;
    end
  end

  assign load      = take;
  assign cl_valid  = (state_q == ST_WALK);
  assign adv       = cl_valid && cl_ready;
  assign bar_valid = (state_q == ST_OPEN) || (state_q == ST_CLOSE);
  assign xlat_off  = bar_valid || cl_valid;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;
endmodule

// File: rtl/line_clean_seq.sv
module line_clean_seq #(
  parameter int AW     = 32,
  parameter int MIN_LG = 4,
  parameter int MAX_LG = 8,
  localparam int LBW   = MAX_LG + 1,
  localparam int LGW   = $clog2(MAX_LG + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [AW-1:0]  range_lo,
  input  logic [AW-1:0]  range_hi,
  input  logic [LGW-1:0] line_lg2,
  input  logic [LBW-1:0] line_bytes,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           xlat_off,
  output logic           bar_valid,
  input  logic           bar_ready,
  output logic           cl_valid,
  input  logic           cl_ready,
  output logic [AW-1:0]  cl_addr
);
  logic [AW-1:0] base;
  logic [AW:0]   lines;
  logic          cfg_bad, load, adv, last;

  lcs_range_calc #(.AW(AW), .LGW(LGW), .LBW(LBW), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG)) u_calc (
    .lo(range_lo), .hi(range_hi), .lg(line_lg2), .lb(line_bytes),
    .base(base), .lines(lines), .cfg_bad(cfg_bad)
  );

  lcs_walker #(.AW(AW), .LBW(LBW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base), .lines(lines),
    .step_bytes(line_bytes), .adv(adv), .addr(cl_addr), .last(last)
  );

  lcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .lines_zero(lines == '0),
    .cfg_bad(cfg_bad), .last(last), .cl_ready(cl_ready), .bar_ready(bar_ready),
    .load(load), .adv(adv), .cl_valid(cl_valid), .bar_valid(bar_valid),
    .xlat_off(xlat_off), .busy(busy), .done(done), .err(err)
  );
endmodule

// File: rtl/lcs_chk.sv
module lcs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          xlat_off,
  input logic          bar_valid,
  input logic          bar_ready,
  input logic          cl_valid,
  input logic          cl_ready,
  input logic [AW-1:0] cl_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xlat_off && !cl_valid && !bar_valid && !done);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid && !cl_ready |=> cl_valid && $stable(cl_addr));

  a_r7_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid && !bar_ready |=> bar_valid);

  a_r6_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid |-> xlat_off && !bar_valid);

  a_r6_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cl_valid) |-> bar_valid && xlat_off);

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid && cl_ready |=> !cl_valid || (cl_addr > $past(cl_addr)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r8_done_restored: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xlat_off && !cl_valid && !bar_valid);
endmodule

bind line_clean_seq lcs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .xlat_off(xlat_off),
  .bar_valid(bar_valid), .bar_ready(bar_ready), .cl_valid(cl_valid),
  .cl_ready(cl_ready), .cl_addr(cl_addr)
);

// File: tb/sim_line_clean_seq.sv
`timescale 1ns/1ps
module sim_line_clean_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [31:0] range_lo = '0, range_hi = '0;
  logic [3:0]  line_lg2 = 4'd4;
  logic [8:0]  line_bytes = 9'd16;
  logic        busy, done, err, xlat_off, bar_valid, cl_valid;
  logic        bar_ready = 1'b0, cl_ready = 1'b0;
  logic [31:0] cl_addr;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  line_clean_seq u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .range_lo(range_lo), .range_hi(range_hi),
    .line_lg2(line_lg2), .line_bytes(line_bytes), .busy(busy), .done(done),
    .err(err), .xlat_off(xlat_off), .bar_valid(bar_valid), .bar_ready(bar_ready),
    .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_addr(cl_addr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_lines(input logic [31:0] lo, hi, input int lg);
    logic [31:0] m, al;
    m  = (32'd1 << lg) - 32'd1;
    al = lo & ~m;
    if (hi < al) return 0;
    return (longint'(hi) - longint'(al) + longint'(m)) >>> lg;
  endfunction

  function automatic bit exp_bad(input int lg, input int lb);
    return (lg < 4) || (lg > 8) || (lb != (1 << lg));
  endfunction

  // ready_mode 0: random back-pressure, 1: always ready
  task automatic run_op(input logic [31:0] lo, hi, input int lg, input int lb,
                        input int ready_mode, input bit glitch);
    longint ecnt, nreq;
    int bars, k;
    bit bad, ord_ok, pend, seen_done;
    logic [31:0] eaddr, paddr;
    bad  = exp_bad(lg, lb);
    ecnt = bad ? 0 : exp_lines(lo, hi, lg);
    eaddr = lo & ~((32'd1 << (lg & 31)) - 32'd1);
    nreq = 0; bars = 0; ord_ok = 1; pend = 0; seen_done = 0; paddr = '0;
    range_lo = lo; range_hi = hi; line_lg2 = lg[3:0]; line_bytes = lb[8:0]; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (k = 0; k < 4000; k++) begin
      if (done) begin seen_done = 1; break; end
      if (glitch && k == 2) begin go = 1'b1; range_lo = lo + 32'h100; end
      if (glitch && k == 3) go = 1'b0;
      if (pend) chk(cl_valid && cl_addr == paddr, "R7 held request", cl_addr, paddr);
      cl_ready  = (ready_mode == 1) ? 1'b1 : 1'($urandom % 2);
      bar_ready = (ready_mode == 1) ? 1'b1 : 1'($urandom % 2);
      if (cl_valid && !xlat_off) ord_ok = 0;
      if (cl_valid && bar_valid) ord_ok = 0;
      if (bar_valid && bar_ready) begin
        bars++;
        if (bars == 1 && nreq != 0) ord_ok = 0;
        if (bars == 2 && nreq != ecnt) ord_ok = 0;
        if (!xlat_off) ord_ok = 0;
      end
      if (cl_valid && cl_ready) begin
        if (bars != 1) ord_ok = 0;
        chk(cl_addr == eaddr, nreq == 0 ? "R2 first address" : "R4 step address", cl_addr, eaddr);
        eaddr = eaddr + 32'(lb);
        nreq++;
      end
      pend  = cl_valid && !cl_ready;
      paddr = cl_addr;
      @(negedge clk);
    end
    cl_ready = 1'b0; bar_ready = 1'b0;
    chk(seen_done, "R8 done seen (watchdog)", seen_done, 1);
    chk(nreq == ecnt, "R3 request count", nreq, ecnt);
    chk(err == bad, "R10 err flag", err, bad);
    chk(bars == ((ecnt > 0) ? 2 : 0), "R6 barrier count", bars, (ecnt > 0) ? 2 : 0);
    chk(ord_ok && !xlat_off, "R6 ordering", ord_ok, 1);
    if (ecnt == 0) chk(k == 0, "R5 immediate done", k, 0);
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {done, busy}, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, xlat_off, bar_valid, cl_valid} == 6'b0, "R1 reset state",
        {busy, done, err, xlat_off, bar_valid, cl_valid}, 0);
    run_op(32'h1000, 32'h1040, 4, 16, 0, 0);
    run_op(32'h1005, 32'h1011, 4, 16, 0, 0);
    run_op(32'h2000, 32'h2000, 4, 16, 0, 0);   // R5 empty
    run_op(32'h2003, 32'h2003, 4, 16, 0, 0);   // formula gives one line
    run_op(32'h3000, 32'h2000, 5, 32, 0, 0);   // stop below start
    run_op(32'h12345, 32'h12800, 8, 256, 1, 0);
    run_op(32'h4000, 32'h4100, 5, 48, 0, 0);   // R10 non power of two
    @(negedge clk);
    chk(err == 1'b1, "R10 err holds while idle", err, 1);
    run_op(32'h4000, 32'h4100, 3, 8, 0, 0);    // R10 below minimum
    run_op(32'h4000, 32'h4100, 9, 0, 0, 0);    // R10 above maximum
    run_op(32'h5010, 32'h5200, 6, 64, 0, 1);   // R9 go while busy
    run_op(32'h6000, 32'h6400, 7, 128, 1, 0);
    for (int n = 0; n < 40; n++) begin
      int lg;
      logic [31:0] lo, hi;
      lg = 4 + int'($urandom % 5);
      lo = $urandom & 32'h7FFF_FFFF;
      hi = (n % 9 == 0) ? lo - ($urandom % 40) : lo + ($urandom % 1500);
      run_op(lo, hi, lg, 1 << lg, int'($urandom % 2), 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule